// File: doc/BRIEF.md
# Configurable Memory Data Protection Unit

This unit sits on a 64-bit memory data path that has eight extra check lanes. A 2-bit protection mode, supplied for the bank being accessed, picks one of four behaviours for those lanes. They can be left unused. They can carry one parity bit per byte, in a plain form or in a form that needs read-modify-write. They can also carry an 8-bit extended Hamming code over the whole 64-bit word, which corrects single errors and detects double errors. A single global input selects odd or even parity. Parity lanes follow the bank's port width.

On the write side the unit builds the check lanes from the write data with no delay. It also reports when a write is too narrow for the selected code and must be done as read-modify-write. On the read side it checks the returned data and check lanes. One cycle after a read beat it presents the data, corrected where ECC allows, together with parity, correctable and uncorrectable flags. A mode that the port width does not allow is reported as a configuration error, and the bank is then handled as unprotected.

Top module: `mem_guard`

## Requirements
- R1: Mode codes: 00 none, 01 parity, 10 RMW parity, 11 ECC. Width codes: 00 8-bit, 01 16-bit, 10 32-bit, 11 64-bit. RMW parity is legal only at width 10 or 11, and ECC only at width 11. An illegal pair sets cfg_err_o and is treated exactly as mode 00.
- R2: In modes 01 and 10, for each active lane k (k below port bytes: 1, 2, 4 or 8), wr_chk_o[k] is the XOR of byte k of wr_data_i, inverted when odd_par_i is 1. Inactive lanes and all lanes in mode 00 drive 0.
- R3: In modes 01 and 10, a read sets par_err_o when any active lane of rd_chk_i differs from the parity of its byte. Inactive lanes and data bytes outside the port are ignored. par_err_o is never set in ECC mode.
- R4: rmw_needed_o is 1 only in legal mode 10 or 11 when wr_be_i, restricted to the active lanes, is nonzero and not all ones. It is 0 in mode 01 and for full or empty enables.
- R5: ECC encoding places check bit i (0 to 6) at code position 2^i and data bit j at the j-th position in 1 to 71, in ascending order, that is not a power of two. wr_chk_o[i] is the XOR of the data bits whose position has bit i set. wr_chk_o[7] is the XOR of all 64 data bits and wr_chk_o[6:0]. odd_par_i has no effect on it.
- R6: In ECC mode, a read with exactly one flipped bit, in the data or in any check lane, sets ce_o, leaves ue_o 0 and returns the original data.
- R7: In ECC mode, a read with two flipped bits sets ue_o, leaves ce_o 0 and returns the received data unchanged. ce_o and ue_o are never both 1.
- R8: rd_valid_o equals rd_valid_i delayed by one clock. rd_data_o and the flags belong to that beat, and the flags are 0 whenever rd_valid_o is 0.
- R9: In mode 00, or in any illegal configuration, rd_data_o is the received data and no error flag is raised, whatever the check lanes hold.
- R10: While rst_ni is low, rd_valid_o, rd_data_o, par_err_o, ce_o and ue_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Protection mode of the accessed bank |
| width_i | input | 2 | Port width code of the accessed bank |
| odd_par_i | input | 1 | 1 selects odd parity, 0 selects even |
| wr_data_i | input | 64 | Write data |
| wr_be_i | input | 8 | Write byte enables |
| wr_chk_o | output | 8 | Check lanes generated for the write |
| rmw_needed_o | output | 1 | Write is partial and needs read-modify-write |
| cfg_err_o | output | 1 | Illegal mode and width pair |
| rd_valid_i | input | 1 | Read beat valid |
| rd_data_i | input | 64 | Read data from memory |
| rd_chk_i | input | 8 | Read check lanes from memory |
| rd_valid_o | output | 1 | Checked read beat valid |
| rd_data_o | output | 64 | Checked, possibly corrected, read data |
| par_err_o | output | 1 | Parity error on the beat |
| ce_o | output | 1 | Corrected single-bit error on the beat |
| ue_o | output | 1 | Uncorrectable error on the beat |

## Verification
A wrong position table in the code shows on wr_chk_o in the same cycle as the write data. On reads it shows one cycle after the beat, as a single flip reported uncorrectable or as the wrong bit being corrected. A wrong lane mask or a wrong legality decode shows at once on wr_chk_o, rmw_needed_o and cfg_err_o. It also shows one cycle after a read as a spurious or missing par_err_o. A slip in the read stage shows on the next clock as rd_valid_o not matching the delayed rd_valid_i, or as flags raised without a valid beat.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;
  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;
  localparam int SYN_W  = 7;
  localparam int CODE_N = DATA_W + SYN_W;

  typedef enum logic [1:0] {PM_NONE = 2'b00, PM_PAR = 2'b01, PM_RMW = 2'b10, PM_ECC = 2'b11} prot_mode_e;
  typedef enum logic [1:0] {PW_8 = 2'b00, PW_16 = 2'b01, PW_32 = 2'b10, PW_64 = 2'b11} port_w_e;

  // code position of data bit j: j-th non-power-of-two in 1..CODE_N
  function automatic int unsigned data_pos(int unsigned j);
    int unsigned n;
    int unsigned r;
    n = 0;
    r = 0;
    for (int unsigned p = 1; p <= CODE_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == j) r = p;
        n++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/mg_cfg.sv
module mg_cfg
  import mem_guard_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic [1:0]         mode_i,
  input  logic [1:0]         width_i,
  output prot_mode_e         eff_mode_o,
  output logic [N_LANES-1:0] lane_en_o,
  output logic               cfg_err_o
);
  logic legal;

  always_comb begin
    unique case (prot_mode_e'(mode_i))
      PM_RMW:  legal = (width_i == PW_32) || (width_i == PW_64);
      PM_ECC:  legal = (width_i == PW_64);
      default: legal = 1'b1;
    endcase
  end

  assign cfg_err_o  = !legal;
  assign eff_mode_o = legal ? prot_mode_e'(mode_i) : PM_NONE;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    assign lane_en_o[k] = (k < (1 << width_i));
  end
endmodule

// File: rtl/mg_parity.sv
module mg_parity #(
  parameter int N_LANES = 8
) (
  input  logic [8*N_LANES-1:0] data_i,
  input  logic                 odd_i,
  input  logic [N_LANES-1:0]   lane_en_i,
  output logic [N_LANES-1:0]   par_o
);
  for (genvar k = 0; k < N_LANES; k++) begin : g_byte
    assign par_o[k] = lane_en_i[k] & ((^data_i[8*k +: 8]) ^ odd_i);
  end
endmodule

// File: rtl/mg_secded_enc.sv
module mg_secded_enc
  import mem_guard_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [SYN_W:0]    chk_o
);
  logic [SYN_W-1:0] pos_w [DATA_W];
  logic [SYN_W-1:0] c;

  for (genvar j = 0; j < DATA_W; j++) begin : g_pos
    assign pos_w[j] = SYN_W'(data_pos(j));
  end

  always_comb begin
    c = '0;
    for (int j = 0; j < DATA_W; j++) c ^= pos_w[j] & {SYN_W{data_i[j]}};
    chk_o = {(^data_i) ^ (^c), c};
  end
endmodule

// File: rtl/mg_secded_dec.sv
module mg_secded_dec
  import mem_guard_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [SYN_W:0]    chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ce_o,
  output logic              ue_o
);
  logic [SYN_W:0]   regen;
  logic [SYN_W-1:0] syn;
  logic             odd_w;
  logic [SYN_W-1:0] pos_w [DATA_W];

  mg_secded_enc u_regen (.data_i(data_i), .chk_o(regen));

  for (genvar j = 0; j < DATA_W; j++) begin : g_pos
    assign pos_w[j] = SYN_W'(data_pos(j));
  end

  assign syn   = regen[SYN_W-1:0] ^ chk_i[SYN_W-1:0];
  // overall parity of the received 72 bits
  assign odd_w = regen[SYN_W] ^ chk_i[SYN_W] ^ (^syn);

  assign ce_o = odd_w && (int'(syn) <= CODE_N);
  assign ue_o = (!odd_w && (syn != '0)) || (odd_w && (int'(syn) > CODE_N));

  always_comb begin
    data_o = data_i;
    for (int j = 0; j < DATA_W; j++)
      if (odd_w && (syn == pos_w[j])) data_o[j] = ~data_i[j];
  end
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mem_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        width_i,
  input  logic              odd_par_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LANES-1:0]  wr_be_i,
  output logic [LANES-1:0]  wr_chk_o,
  output logic              rmw_needed_o,
  output logic              cfg_err_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [LANES-1:0]  rd_chk_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              par_err_o,
  output logic              ce_o,
  output logic              ue_o
);
  prot_mode_e        eff_mode;
  logic [LANES-1:0]  lane_en, par_wr, par_rd, be_act;
  logic [SYN_W:0]    ecc_wr;
  logic [DATA_W-1:0] ecc_fix;
  logic              ecc_ce, ecc_ue, is_par, is_ecc, par_hit;

  logic              v_q, par_q, ce_q, ue_q;
  logic [DATA_W-1:0] data_q;

  mg_cfg u_cfg (
    .mode_i(mode_i), .width_i(width_i),
    .eff_mode_o(eff_mode), .lane_en_o(lane_en), .cfg_err_o(cfg_err_o)
  );

  mg_parity #(.N_LANES(LANES)) u_par_wr (
    .data_i(wr_data_i), .odd_i(odd_par_i), .lane_en_i(lane_en), .par_o(par_wr)
  );

  mg_parity #(.N_LANES(LANES)) u_par_rd (
    .data_i(rd_data_i), .odd_i(odd_par_i), .lane_en_i(lane_en), .par_o(par_rd)
  );

  mg_secded_enc u_enc (.data_i(wr_data_i), .chk_o(ecc_wr));

  mg_secded_dec u_dec (
    .data_i(rd_data_i), .chk_i(rd_chk_i),
    .data_o(ecc_fix), .ce_o(ecc_ce), .ue_o(ecc_ue)
  );

  assign is_par = (eff_mode == PM_PAR) || (eff_mode == PM_RMW);
  assign is_ecc = (eff_mode == PM_ECC);

  // write side
  always_comb begin
    unique case (eff_mode)
      PM_PAR, PM_RMW: wr_chk_o = par_wr;
      PM_ECC:         wr_chk_o = ecc_wr;
      default:        wr_chk_o = '0;
    endcase
  end

  assign be_act       = wr_be_i & lane_en;
  assign rmw_needed_o = ((eff_mode == PM_RMW) || is_ecc) && (be_act != '0) && (be_act != lane_en);

  // read side
  assign par_hit = |((par_rd ^ rd_chk_i) & lane_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      par_q  <= 1'b0;
      ce_q   <= 1'b0;
      ue_q   <= 1'b0;
      data_q <= '0;
    end else begin
      v_q   <= rd_valid_i;
      par_q <= rd_valid_i && is_par && par_hit;
      ce_q  <= rd_valid_i && is_ecc && ecc_ce;
      ue_q  <= rd_valid_i && is_ecc && ecc_ue;
      if (rd_valid_i) data_q <= is_ecc ? ecc_fix : rd_data_i;
    end
  end

  assign rd_valid_o = v_q;
  assign rd_data_o  = data_q;
  assign par_err_o  = par_q;
  assign ce_o       = ce_q;
  assign ue_o       = ue_q;
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  mode_i,
  input logic [7:0]  wr_chk_o,
  input logic        rmw_needed_o,
  input logic        cfg_err_o,
  input logic        rd_valid_i,
  input logic [63:0] rd_data_i,
  input logic        rd_valid_o,
  input logic [63:0] rd_data_o,
  input logic        par_err_o,
  input logic        ce_o,
  input logic        ue_o
);
  // R8
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_valid_o);
  // R8
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> !rd_valid_o);
  // R8
  flags_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o || ce_o || ue_o) |-> rd_valid_o);
  // R7
  ce_ue_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_o && ue_o));
  // R1
  cfg_unprot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (wr_chk_o == 8'h00 && !rmw_needed_o));
  // R9
  none_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && mode_i == 2'b00) |=>
      (rd_data_o == $past(rd_data_i) && !par_err_o && !ce_o && !ue_o));
  // R3
  ecc_no_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && mode_i == 2'b11) |=> !par_err_o);
endmodule

bind mem_guard mem_guard_chk u_chk (.*);

// File: tb/mem_guard_test.sv
module mem_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00, width = 2'b11;
  logic        odd = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_be = '0;
  logic [7:0]  wr_chk;
  logic        rmw, cfg_err;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_chk = '0;
  logic        v_o, par_o, ce_o, ue_o;
  logic [63:0] d_o;

  int n_chk = 0, n_err = 0;
  int pos_tab [64];
  logic v_prev = 1'b0;

  always #5 clk = ~clk;

  mem_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .width_i(width), .odd_par_i(odd),
    .wr_data_i(wr_data), .wr_be_i(wr_be), .wr_chk_o(wr_chk), .rmw_needed_o(rmw),
    .cfg_err_o(cfg_err), .rd_valid_i(rd_valid), .rd_data_i(rd_data), .rd_chk_i(rd_chk),
    .rd_valid_o(v_o), .rd_data_o(d_o), .par_err_o(par_o), .ce_o(ce_o), .ue_o(ue_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_ecc(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 64; j++)
        if (((pos_tab[j] >> i) & 1) == 1) c[i] = c[i] ^ d[j];
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  function automatic logic [7:0] ref_par(input logic [63:0] d, input logic o, input int nl);
    logic [7:0] p = '0;
    for (int k = 0; k < nl; k++) p[k] = (^d[8*k +: 8]) ^ o;
    return p;
  endfunction

  // per-clock monitor of the read stage
  always @(posedge clk) v_prev <= rd_valid;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 valid delay", 64'(v_o), 64'(v_prev));
      if (!v_o) chk("R8 idle flags", {61'd0, par_o, ce_o, ue_o}, 64'd0);
    end
  end

  task automatic wr(input logic [1:0] m, input logic [1:0] w, input logic o,
                    input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    mode = m; width = w; odd = o; wr_data = d; wr_be = be;
    #1;
  endtask

  task automatic rd(input string req, input logic [1:0] m, input logic [1:0] w, input logic o,
                    input logic [63:0] d, input logic [7:0] c,
                    input logic [63:0] exp_d, input logic exp_p, input logic exp_ce, input logic exp_ue);
    @(negedge clk);
    mode = m; width = w; odd = o; rd_data = d; rd_chk = c; rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk({req, " data"}, d_o, exp_d);
    chk({req, " flags"}, {61'd0, par_o, ce_o, ue_o}, {61'd0, exp_p, exp_ce, exp_ue});
  endtask

  localparam logic [63:0] D1 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] D2 = 64'hF00D_CAFE_1357_9BDF;

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] e;
    begin
      int k = 0;
      for (int p = 1; p < 72; p++)
        if ((p & (p - 1)) != 0) begin pos_tab[k] = p; k++; end
    end

    // R10 reset state
    rd_valid = 1'b1; rd_data = D1;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {d_o[62:0], v_o}, 64'd0);
    chk("R10 reset flags", {61'd0, par_o, ce_o, ue_o}, 64'd0);
    rd_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R2 parity generation, 64-bit even and odd
    wr(2'b01, 2'b11, 1'b0, D1, 8'hFF);
    chk("R2 even par 64", wr_chk, ref_par(D1, 1'b0, 8));
    chk("R4 normal parity no rmw", 64'(rmw), 0);
    wr(2'b10, 2'b11, 1'b1, D2, 8'hFF);
    chk("R2 odd par 64 rmw mode", wr_chk, ref_par(D2, 1'b1, 8));
    // R2 32-bit port: upper lanes zero
    wr(2'b01, 2'b10, 1'b1, D1, 8'h0F);
    chk("R2 odd par 32", wr_chk, ref_par(D1, 1'b1, 4));
    wr(2'b01, 2'b00, 1'b0, D2, 8'h01);
    chk("R2 even par 8", wr_chk, ref_par(D2, 1'b0, 1));
    wr(2'b00, 2'b11, 1'b0, D1, 8'hFF);
    chk("R2 none mode zero", wr_chk, 0);

    // R4 rmw indication
    wr(2'b10, 2'b11, 1'b0, D1, 8'h0F);
    chk("R4 rmw partial 64", 64'(rmw), 1);
    wr(2'b10, 2'b11, 1'b0, D1, 8'h00);
    chk("R4 rmw empty", 64'(rmw), 0);
    wr(2'b10, 2'b10, 1'b0, D1, 8'h0F);
    chk("R4 rmw full 32", 64'(rmw), 0);
    wr(2'b10, 2'b10, 1'b0, D1, 8'h03);
    chk("R4 rmw partial 32", 64'(rmw), 1);
    wr(2'b11, 2'b11, 1'b0, D1, 8'hFE);
    chk("R4 ecc partial", 64'(rmw), 1);

    // R1 legality
    wr(2'b10, 2'b00, 1'b0, D1, 8'h00);
    chk("R1 rmw on 8-bit cfg err", {62'd0, cfg_err, rmw}, 64'd2);
    chk("R1 rmw on 8-bit unprot chk", wr_chk, 0);
    wr(2'b11, 2'b10, 1'b0, D1, 8'h03);
    chk("R1 ecc on 32-bit", {wr_chk, 54'd0, cfg_err, rmw}, 64'd2);
    wr(2'b01, 2'b01, 1'b0, D1, 8'h03);
    chk("R1 parity on 16-bit legal", 64'(cfg_err), 0);

    // R5 ecc encoding, independent of odd select
    wr(2'b11, 2'b11, 1'b0, D1, 8'hFF);
    chk("R5 ecc D1", wr_chk, ref_ecc(D1));
    wr(2'b11, 2'b11, 1'b1, D2, 8'hFF);
    chk("R5 ecc D2 odd sel", wr_chk, ref_ecc(D2));

    // R3 parity reads
    e = ref_par(D1, 1'b0, 8);
    rd("R3 clean 64", 2'b01, 2'b11, 1'b0, D1, e, D1, 1'b0, 1'b0, 1'b0);
    rd("R3 lane3 bad", 2'b01, 2'b11, 1'b0, D1, e ^ 8'h08, D1, 1'b1, 1'b0, 1'b0);
    e = ref_par(D2, 1'b1, 4);
    rd("R3 32 upper ignored", 2'b10, 2'b10, 1'b1, D2, e | 8'hA0, D2, 1'b0, 1'b0, 1'b0);
    rd("R3 32 upper data ignored", 2'b01, 2'b10, 1'b1, D2 ^ 64'h0000_2000_0000_0000, e,
       D2 ^ 64'h0000_2000_0000_0000, 1'b0, 1'b0, 1'b0);
    rd("R3 32 byte1 bad", 2'b01, 2'b10, 1'b1, D2 ^ 64'h200, e, D2 ^ 64'h200, 1'b1, 1'b0, 1'b0);

    // R9 unprotected reads
    rd("R9 none mode", 2'b00, 2'b11, 1'b0, D1, 8'h5A, D1, 1'b0, 1'b0, 1'b0);
    rd("R9 illegal cfg", 2'b10, 2'b00, 1'b0, D2, 8'hFF, D2, 1'b0, 1'b0, 1'b0);

    // R6 / R7 ecc reads
    e = ref_ecc(D1);
    rd("R6 ecc clean", 2'b11, 2'b11, 1'b0, D1, e, D1, 1'b0, 1'b0, 1'b0);
    rd("R6 ecc data bit0", 2'b11, 2'b11, 1'b0, D1 ^ 64'h1, e, D1, 1'b0, 1'b1, 1'b0);
    rd("R6 ecc data bit63", 2'b11, 2'b11, 1'b0, D1 ^ (64'h1 << 63), e, D1, 1'b0, 1'b1, 1'b0);
    rd("R6 ecc chk bit3", 2'b11, 2'b11, 1'b0, D1, e ^ 8'h08, D1, 1'b0, 1'b1, 1'b0);
    rd("R6 ecc chk bit7", 2'b11, 2'b11, 1'b1, D1, e ^ 8'h80, D1, 1'b0, 1'b1, 1'b0);
    e = ref_ecc(D2);
    rd("R6 ecc D2 bit30", 2'b11, 2'b11, 1'b0, D2 ^ (64'h1 << 30), e, D2, 1'b0, 1'b1, 1'b0);
    rd("R7 ecc two data bits", 2'b11, 2'b11, 1'b0, D2 ^ (64'h1 << 5) ^ (64'h1 << 40), e,
       D2 ^ (64'h1 << 5) ^ (64'h1 << 40), 1'b0, 1'b0, 1'b1);
    rd("R7 ecc data and chk", 2'b11, 2'b11, 1'b0, D2 ^ 64'h100, e ^ 8'h01,
       D2 ^ 64'h100, 1'b0, 1'b0, 1'b1);
    rd("R7 ecc two chk", 2'b11, 2'b11, 1'b0, D2, e ^ 8'h82, D2, 1'b0, 1'b0, 1'b1);

    // R8 back-to-back beats
    @(negedge clk);
    mode = 2'b11; width = 2'b11; rd_data = D1 ^ 64'h4; rd_chk = ref_ecc(D1); rd_valid = 1'b1;
    @(negedge clk);
    rd_data = D2; rd_chk = ref_ecc(D2);
    chk("R8 beat1 data", d_o, D1);
    chk("R8 beat1 ce", 64'(ce_o), 1);
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R8 beat2 data", d_o, D2);
    chk("R8 beat2 ce", 64'(ce_o), 0);
    repeat (2) @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule